// File: doc/BRIEF.md
# DSP Register–Memory Move Unit

This block runs the DSP-side load and store instructions that move one value between a register and memory. In the same cycle it decodes a 16-bit opcode, forms the effective address from one of four address registers, and drives a byte-addressed memory port. On the next clock edge it writes back the updated address register and, for a load, the destination register. The address register can be pre-decremented, used unchanged, post-incremented, or advanced by its paired index register.

The memory is 32 bits wide and big-endian. A 16-bit transfer always uses the upper half of a 32-bit data register. A load clears the lower half, and a store sends only the upper half. Each of the two 8-bit guard registers is sign-extended when it is the source of a store. The rest of the core loads the address, index, data and guard registers through a side write port. An opcode with a bad prefix or a reserved register code is flagged as illegal. An access that breaks alignment is flagged as an address error. In both cases no access is made and nothing is updated.

Top module: `dsp_xfer_unit`

## Requirements
- R1: With `insn_valid` high, an opcode whose bits [15:10] are not 111101, or whose register field [7:4] is 10 to 15, raises `illegal`. It makes no memory access and leaves every register unchanged. The opcode fields are address select [9:8], register select [7:4], mode [3:2], size [1] and direction [0].
- R2: Mode 00 pre-decrements the address register and accesses the new value. Mode 01 accesses the register and leaves it unchanged. Mode 10 accesses the register and then adds the step to it. Mode 11 accesses the register and then adds the index register with the same number.
- R3: The step is 2 when size bit 1 is 0 (16-bit word) and 4 when it is 1 (32-bit longword).
- R4: A word load writes the memory halfword into bits [31:16] of the destination and zero into bits [15:0]. A longword load writes all 32 bits.
- R5: Direction bit 0 set means a store (`mem_we` high). A longword store drives all 32 bits with `mem_be`=1111. A word store places bits [31:16] of the source on lanes [31:16] with `mem_be`=1100 when address bit 1 is 0, or on lanes [15:0] with `mem_be`=0011 when it is 1. The unused lanes are zero.
- R6: A word load takes `mem_rdata[31:16]` when address bit 1 is 0 and `mem_rdata[15:0]` when it is 1.
- R7: Register codes 0 to 7 select the data registers and codes 8 and 9 select the guard registers. A guard register used as a store source is sign-extended from 8 to 32 bits. A guard register used as a load destination takes bits [7:0] of the value a data register would receive.
- R8: A longword access with address bits [1:0] not 00, or a word access with address bit 0 set, raises `addr_err`. It makes no memory access and causes no register update.
- R9: Each instruction takes one cycle. Its register results are visible to the instruction in the very next cycle.
- R10: When `insn_valid` is low, `rf_we` writes `rf_wdata` to the register named by `rf_sel`. With bit 4 clear, `rf_sel` names a register code as in R7, and codes 10 to 15 are ignored. With bits [4:3]=10 it names address register [1:0], and with [4:3]=11 it names index register [1:0]. The side write is ignored when `insn_valid` is high.
- R11: After reset all registers read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| insn_valid | input | 1 | An instruction is presented this cycle |
| insn | input | 16 | Instruction opcode |
| rf_we | input | 1 | Side register write enable |
| rf_sel | input | 5 | Side write register select |
| rf_wdata | input | 32 | Side write data |
| mem_en | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_be | output | 4 | Byte lane enables, bit 3 is the lowest address |
| mem_addr | output | AW | Byte address |
| mem_wdata | output | 32 | Store data |
| mem_rdata | input | 32 | Read data for the current address, same cycle |
| illegal | output | 1 | Illegal opcode flag |
| addr_err | output | 1 | Misaligned access flag |

## Verification
Some properties are checked on every cycle. A faulting instruction never reaches the memory port, and the two fault flags are never both set. The number of enabled lanes matches the size, and a word's lanes agree with address bit 1. Any enabled address is aligned. A write never appears without an enabled store. The bench's reference model and scenarios are the only way to show the arithmetic: pre-decrement, post-increment and index update values, half placement on loads, guard sign extension, and the absence of side effects after a fault. These show up only when a later store exposes register contents.

// File: rtl/dsp_xfer_unit.sv
module dsp_xfer_unit #(
  parameter int AW = 32,
  parameter int GW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          insn_valid,
  input  logic [15:0]   insn,
  input  logic          rf_we,
  input  logic [4:0]    rf_sel,
  input  logic [31:0]   rf_wdata,
  output logic          mem_en,
  output logic          mem_we,
  output logic [3:0]    mem_be,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic [31:0]   mem_rdata,
  output logic          illegal,
  output logic          addr_err
);
  localparam int NA = 4;
  localparam int ND = 8;
  localparam int NG = 2;
  localparam logic [5:0] PFX = 6'b111101;

  logic [AW-1:0] areg [NA];
  logic [AW-1:0] ireg [NA];
  logic [31:0]   dreg [ND];
  logic [GW-1:0] greg [NG];

  wire [1:0] an       = insn[9:8];
  wire [3:0] dn       = insn[7:4];
  wire [1:0] mode     = insn[3:2];
  wire       is_long  = insn[1];
  wire       is_store = insn[0];

  wire [AW-1:0] step  = is_long ? AW'(4) : AW'(2);
  wire [AW-1:0] abase = areg[an];
  wire [AW-1:0] ea    = (mode == 2'b00) ? abase - step : abase;

  logic [AW-1:0] anext;
  always_comb begin
    case (mode)
      2'b00:   anext = ea;
      2'b01:   anext = abase;
      2'b10:   anext = abase + step;
      default: anext = abase + ireg[an];
    endcase
  end

  wire misal = is_long ? (ea[1:0] != 2'b00) : ea[0];
  assign illegal  = insn_valid && ((insn[15:10] != PFX) || (dn > 4'd9));
  assign addr_err = insn_valid && !illegal && misal;
  wire go = insn_valid && !illegal && !misal;

  logic [31:0] src;
  always_comb begin
    if (dn[3]) src = {{(32-GW){greg[dn[0]][GW-1]}}, greg[dn[0]]};
    else       src = dreg[dn[2:0]];
  end

  wire [15:0] rd_half = ea[1] ? mem_rdata[15:0] : mem_rdata[31:16];
  wire [31:0] ld      = is_long ? mem_rdata : {rd_half, 16'h0000};

  assign mem_en    = go;
  assign mem_we    = go && is_store;
  assign mem_addr  = ea;
  assign mem_be    = !go ? 4'h0 : is_long ? 4'hF : (ea[1] ? 4'h3 : 4'hC);
  assign mem_wdata = is_long ? src :
                     (ea[1] ? {16'h0000, src[31:16]} : {src[31:16], 16'h0000});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NA; k++) begin
        areg[k] <= '0;
        ireg[k] <= '0;
      end
      for (int k = 0; k < ND; k++) dreg[k] <= '0;
      for (int k = 0; k < NG; k++) greg[k] <= '0;
    end else if (go) begin
      areg[an] <= anext;
      if (!is_store) begin
        if (dn[3]) greg[dn[0]] <= ld[GW-1:0];
        else       dreg[dn[2:0]] <= ld;
      end
    end else if (rf_we && !insn_valid) begin
      if (rf_sel[4]) begin
        if (rf_sel[3]) ireg[rf_sel[1:0]] <= rf_wdata[AW-1:0];
        else           areg[rf_sel[1:0]] <= rf_wdata[AW-1:0];
      end else if (rf_sel[3:0] < 4'd8) begin
        dreg[rf_sel[2:0]] <= rf_wdata;
      end else if (rf_sel[3:0] < 4'd10) begin
        greg[rf_sel[0]] <= rf_wdata[GW-1:0];
      end
    end
  end
endmodule

// File: rtl/dsp_xfer_unit_chk.sv
module dsp_xfer_unit_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          insn_valid,
  input logic [15:0]   insn,
  input logic          mem_en,
  input logic          mem_we,
  input logic [3:0]    mem_be,
  input logic [AW-1:0] mem_addr,
  input logic          illegal,
  input logic          addr_err
);
  a_r1_illegal_no_access: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> !mem_en && !mem_we);

  a_r8_misaligned_no_access: assert property (@(posedge clk) disable iff (!rst_n)
    addr_err |-> !mem_en && !mem_we);

  a_r1_faults_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(illegal && addr_err));

  a_r5_lane_count: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en |-> ($countones(mem_be) == (insn[1] ? 4 : 2)));

  a_r5_word_lanes: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && !insn[1]) |-> (mem_be == (mem_addr[1] ? 4'h3 : 4'hC)));

  a_r8_aligned_access: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en |-> (insn[1] ? (mem_addr[1:0] == 2'b00) : !mem_addr[0]));

  a_r9_same_cycle_only: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en |-> insn_valid);

  a_r5_write_is_store: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_en && insn[0]);

  a_r5_idle_lanes: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_en |-> (mem_be == 4'h0));
endmodule

bind dsp_xfer_unit dsp_xfer_unit_chk #(.AW(AW)) u_chk (.*);

// File: tb/dsp_xfer_unit_tb.sv
module dsp_xfer_unit_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        insn_valid = 1'b0;
  logic [15:0] insn = '0;
  logic        rf_we = 1'b0;
  logic [4:0]  rf_sel = '0;
  logic [31:0] rf_wdata = '0;
  logic        mem_en, mem_we, illegal, addr_err;
  logic [3:0]  mem_be;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;

  logic [31:0] bmem [64];
  logic [31:0] m_a [4];
  logic [31:0] m_i [4];
  logic [31:0] m_d [8];
  logic [7:0]  m_g [2];

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;
  string cur_req = "R11";

  logic        e_ill, e_aerr, e_en, e_we;
  logic [3:0]  e_be;
  logic [31:0] e_ea, e_na, e_wd, e_ld;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign mem_rdata = bmem[mem_addr[7:2]];

  dsp_xfer_unit u_dut (
    .clk(clk), .rst_n(rst_n), .insn_valid(insn_valid), .insn(insn),
    .rf_we(rf_we), .rf_sel(rf_sel), .rf_wdata(rf_wdata),
    .mem_en(mem_en), .mem_we(mem_we), .mem_be(mem_be), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .illegal(illegal), .addr_err(addr_err)
  );

  function automatic logic [15:0] op(input logic [1:0] an, input logic [3:0] dn,
                                     input logic [1:0] md, input logic lw, input logic st);
    return {6'b111101, an, dn, md, lw, st};
  endfunction

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", cur_req, what, act, exp);
    end
  endtask

  task automatic model_eval(input logic v, input logic [15:0] ins);
    logic [1:0] an, md; logic [3:0] dn; logic lw; logic [31:0] a, sz, src, rd;
    an = ins[9:8]; dn = ins[7:4]; md = ins[3:2]; lw = ins[1];
    e_ill = v && (ins[15:10] != 6'b111101 || dn > 4'd9);
    a = m_a[an];
    sz = lw ? 32'd4 : 32'd2;
    e_ea = (md == 2'd0) ? a - sz : a;
    case (md)
      2'd0: e_na = e_ea;
      2'd1: e_na = a;
      2'd2: e_na = a + sz;
      default: e_na = a + m_i[an];
    endcase
    e_aerr = v && !e_ill && (lw ? (e_ea[1:0] != 2'd0) : e_ea[0]);
    e_en = v && !e_ill && !e_aerr;
    e_we = e_en && ins[0];
    src = (dn < 4'd8) ? m_d[dn[2:0]] : {{24{m_g[dn[0]][7]}}, m_g[dn[0]]};
    e_be = lw ? 4'hF : (e_ea[1] ? 4'h3 : 4'hC);
    e_wd = lw ? src : (e_ea[1] ? {16'h0, src[31:16]} : {src[31:16], 16'h0});
    rd = bmem[e_ea[7:2]];
    e_ld = lw ? rd : {(e_ea[1] ? rd[15:0] : rd[31:16]), 16'h0};
  endtask

  task automatic model_commit(input logic v, input logic [15:0] ins,
                              input logic rw, input logic [4:0] rs, input logic [31:0] rd);
    logic [3:0] dn;
    dn = ins[7:4];
    if (e_en) begin
      m_a[ins[9:8]] = e_na;
      if (ins[0]) begin
        for (int b = 0; b < 4; b++)
          if (e_be[3-b]) bmem[e_ea[7:2]][31-8*b -: 8] = e_wd[31-8*b -: 8];
      end else if (dn < 4'd8) m_d[dn[2:0]] = e_ld;
      else m_g[dn[0]] = e_ld[7:0];
    end else if (!v && rw) begin
      if (rs[4]) begin
        if (rs[3]) m_i[rs[1:0]] = rd; else m_a[rs[1:0]] = rd;
      end else if (rs[3:0] < 4'd8) m_d[rs[2:0]] = rd;
      else if (rs[3:0] < 4'd10) m_g[rs[0]] = rd[7:0];
    end
  endtask

  task automatic step(input logic v, input logic [15:0] ins,
                      input logic rw, input logic [4:0] rs, input logic [31:0] rd);
    @(negedge clk);
    insn_valid = v; insn = ins; rf_we = rw; rf_sel = rs; rf_wdata = rd;
    #1;
    model_eval(v, ins);
    chk("illegal", {31'd0, illegal}, {31'd0, e_ill});
    chk("addr_err", {31'd0, addr_err}, {31'd0, e_aerr});
    chk("mem_en", {31'd0, mem_en}, {31'd0, e_en});
    chk("mem_we", {31'd0, mem_we}, {31'd0, e_we});
    if (e_en) begin
      chk("mem_addr", mem_addr, e_ea);
      chk("mem_be", {28'd0, mem_be}, {28'd0, e_be});
    end
    if (e_we) chk("mem_wdata", mem_wdata, e_wd);
    @(posedge clk);
    #1;
    model_commit(v, ins, rw, rs, rd);
  endtask

  task automatic exec(input logic [15:0] ins);
    step(1'b1, ins, 1'b0, 5'd0, 32'd0);
  endtask

  task automatic wr(input logic [4:0] rs, input logic [31:0] val);
    step(1'b0, 16'h0, 1'b1, rs, val);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 64; k++) bmem[k] = (k + 1) * 32'h01030507 ^ 32'h80F01020;
    for (int k = 0; k < 4; k++) begin m_a[k] = 0; m_i[k] = 0; end
    for (int k = 0; k < 8; k++) m_d[k] = 0;
    for (int k = 0; k < 2; k++) m_g[k] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    cur_req = "R11";
    for (int k = 0; k < 10; k++) exec(op(2'd0, k[3:0], 2'd1, 1'b1, 1'b1));

    cur_req = "R10";
    wr(5'h10, 32'h40); wr(5'h11, 32'h80); wr(5'h12, 32'h22); wr(5'h13, 32'hC0);
    wr(5'h18, 32'h8); wr(5'h19, 32'h4); wr(5'h1A, 32'hFFFFFFFC); wr(5'h1B, 32'h6);
    for (int k = 0; k < 8; k++) wr(k[4:0], 32'h11223344 * (k + 1) + 32'h5A5A0000);
    wr(5'h08, 32'h85); wr(5'h09, 32'h7A);
    wr(5'h0C, 32'hDEADBEEF);
    step(1'b1, op(2'd0, 4'd3, 2'd1, 1'b1, 1'b1), 1'b1, 5'h03, 32'hFFFF0000);
    exec(op(2'd0, 4'd3, 2'd1, 1'b1, 1'b1));
    for (int k = 0; k < 8; k++) exec(op(2'd0, k[3:0], 2'd1, 1'b1, 1'b1));

    cur_req = "R2";
    exec(op(2'd1, 4'd1, 2'd0, 1'b0, 1'b1));
    exec(op(2'd1, 4'd1, 2'd1, 1'b0, 1'b1));
    exec(op(2'd1, 4'd1, 2'd2, 1'b0, 1'b1));
    exec(op(2'd1, 4'd1, 2'd1, 1'b1, 1'b1));
    cur_req = "R3";
    exec(op(2'd1, 4'd2, 2'd2, 1'b1, 1'b1));
    exec(op(2'd1, 4'd2, 2'd0, 1'b1, 1'b1));
    exec(op(2'd1, 4'd2, 2'd1, 1'b1, 1'b1));
    cur_req = "R2";
    exec(op(2'd1, 4'd2, 2'd3, 1'b1, 1'b1));
    exec(op(2'd1, 4'd2, 2'd1, 1'b1, 1'b1));
    exec(op(2'd2, 4'd0, 2'd3, 1'b0, 1'b1));
    exec(op(2'd2, 4'd0, 2'd1, 1'b0, 1'b1));

    cur_req = "R4";
    wr(5'h10, 32'h40);
    exec(op(2'd0, 4'd4, 2'd1, 1'b0, 1'b0));
    exec(op(2'd0, 4'd4, 2'd1, 1'b1, 1'b1));
    exec(op(2'd0, 4'd5, 2'd1, 1'b1, 1'b0));
    exec(op(2'd0, 4'd5, 2'd1, 1'b1, 1'b1));
    cur_req = "R6";
    wr(5'h10, 32'h42);
    exec(op(2'd0, 4'd6, 2'd1, 1'b0, 1'b0));
    wr(5'h10, 32'h40);
    exec(op(2'd0, 4'd6, 2'd1, 1'b1, 1'b1));
    cur_req = "R5";
    wr(5'h10, 32'h50);
    exec(op(2'd0, 4'd7, 2'd1, 1'b0, 1'b1));
    wr(5'h10, 32'h52);
    exec(op(2'd0, 4'd7, 2'd1, 1'b0, 1'b1));
    wr(5'h10, 32'h50);
    exec(op(2'd0, 4'd7, 2'd1, 1'b1, 1'b0));
    exec(op(2'd0, 4'd7, 2'd1, 1'b1, 1'b1));

    cur_req = "R7";
    exec(op(2'd0, 4'd8, 2'd1, 1'b1, 1'b1));
    exec(op(2'd0, 4'd8, 2'd1, 1'b0, 1'b1));
    exec(op(2'd0, 4'd9, 2'd1, 1'b1, 1'b1));
    exec(op(2'd0, 4'd9, 2'd1, 1'b1, 1'b0));
    exec(op(2'd0, 4'd9, 2'd1, 1'b1, 1'b1));
    exec(op(2'd0, 4'd9, 2'd1, 1'b0, 1'b0));
    exec(op(2'd0, 4'd9, 2'd1, 1'b1, 1'b1));

    cur_req = "R8";
    exec(op(2'd2, 4'd1, 2'd2, 1'b1, 1'b0));
    exec(op(2'd2, 4'd1, 2'd1, 1'b0, 1'b1));
    exec(op(2'd0, 4'd1, 2'd1, 1'b1, 1'b1));
    wr(5'h13, 32'h41);
    exec(op(2'd3, 4'd2, 2'd0, 1'b0, 1'b0));
    exec(op(2'd3, 4'd2, 2'd2, 1'b0, 1'b1));
    exec(op(2'd0, 4'd2, 2'd1, 1'b1, 1'b1));

    cur_req = "R1";
    wr(5'h10, 32'h60);
    exec({6'b111100, 2'd0, 4'd3, 2'd2, 1'b1, 1'b0});
    exec(op(2'd0, 4'd12, 2'd2, 1'b1, 1'b0));
    exec(op(2'd0, 4'd15, 2'd0, 1'b0, 1'b1));
    exec(op(2'd0, 4'd3, 2'd1, 1'b1, 1'b1));

    cur_req = "R9";
    exec(op(2'd0, 4'd0, 2'd2, 1'b1, 1'b0));
    exec(op(2'd0, 4'd0, 2'd0, 1'b1, 1'b1));
    exec(op(2'd0, 4'd0, 2'd1, 1'b1, 1'b1));

    cur_req = "R2 R3 R4 R5 R6 R7 mixed";
    for (int n = 0; n < 1500; n++) begin
      int r;
      r = $urandom % 16;
      if (r == 0) wr(5'h10 | 5'($urandom % 4), $urandom & 32'hFC);
      else if (r == 1) wr(5'($urandom % 32), $urandom);
      else begin
        logic [15:0] ins;
        ins = op(2'($urandom % 4), 4'($urandom % 10), 2'($urandom % 4),
                 1'($urandom % 2), 1'($urandom % 2));
        if ($urandom % 16 == 0) ins[7:4] = 4'($urandom);
        if ($urandom % 32 == 0) ins[15:10] = 6'($urandom);
        exec(ins);
      end
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule